// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is a register of `W` bits (eight by default) that holds its value, moves it one place toward the high end, moves it one place toward the low end, or takes a new word from a parallel port. A two-bit mode input picks the operation, and every change happens on the rising clock edge. The parallel port shares one set of terminals for input and output. The block shows it as three vectors: the level seen on the terminals (`pad_in`), the value it would drive (`pad_out`), and a per-bit drive enable (`pad_oe`). A pad ring outside the block turns these three vectors into real tri-state terminals.

Two active-low enables control the drive. The terminals are driven only when both enables are low. The block also releases them by itself whenever it is loading, so the incoming word can reach the register. Two serial outputs show the lowest and highest register bits at all times. An active-low clear sets the register to zero. The parameter `CLEAR_SYNC` picks how the clear acts: with 0 it acts at once, without waiting for the clock; with 1 it acts only on a rising edge.

Top module: `univ_shreg`

## Requirements
- R1: With `mode_sel` = 2'b00 (hold), the register keeps its value across a rising edge.
- R2: With `mode_sel` = 2'b01 (shift toward the high end), bit 0 takes `ser_rin` and each bit i > 0 takes the old bit i-1. Arithmetically, new = (old*2 + ser_rin) mod 2^W.
- R3: With `mode_sel` = 2'b10 (shift toward the low end), bit W-1 takes `ser_lin` and each bit i < W-1 takes the old bit i+1. Arithmetically, new = old/2 + ser_lin*2^(W-1).
- R4: With `mode_sel` = 2'b11 (load), the register captures `pad_in` at the rising edge.
- R5: `pad_oe` is all ones when `oe_a_n` and `oe_b_n` are both low and `mode_sel` is not 2'b11. In every other case it is all zeros.
- R6: `pad_out` always equals the register contents, whatever the enables are.
- R7: `end_lo` equals register bit 0 and `end_hi` equals register bit W-1 at all times. The output enables do not affect them.
- R8: With `CLEAR_SYNC` = 0, a low `clr_n` zeroes the register at once, before any clock edge.
- R9: With `CLEAR_SYNC` = 1, a low `clr_n` zeroes the register only at a rising edge. A low pulse on `clr_n` that ends before an edge has no effect.
- R10: Clear wins over every mode, including load with `pad_in` all ones.
- R11: Shifting and loading work the same when either output enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; timing set by `CLEAR_SYNC` |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_rin | input | 1 | Serial bit entering bit 0 on a shift up |
| ser_lin | input | 1 | Serial bit entering bit W-1 on a shift down |
| oe_a_n | input | 1 | Active-low output enable A |
| oe_b_n | input | 1 | Active-low output enable B |
| pad_in | input | W | Level seen on the shared terminals |
| pad_out | output | W | Value offered to the shared terminals |
| pad_oe | output | W | Per-bit drive enable for the shared terminals |
| end_lo | output | 1 | Register bit 0, never tri-stated |
| end_hi | output | 1 | Register bit W-1, never tri-stated |

## Verification
The hardest case to reach from the ports is a clear that falls between clock edges. It must zero the asynchronous variant at once, while the synchronous variant keeps its value; a clear pulse that ends before an edge must leave the synchronous variant unchanged. The bench runs one instance of each variant side by side, each with its own clear line, and changes those lines at mid-cycle offsets. It reads both instances before and after the next edge. The rest of the stimulus loads all 2^W words and runs every mode with every pair of serial bits from a spread of starting values. It repeats part of this with the enables high, to show the register still updates when the port is released.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

endpackage

// File: rtl/ushr_next.sv
module ushr_next
  import ushr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  mode_e        mode,
  input  logic         rin,
  input  logic         lin,
  input  logic [W-1:0] pin,
  output logic [W-1:0] nxt,
  output logic         load_evt,
  output logic         move_evt
);

  // move every bit one place toward the top, fill bit 0
  function automatic logic [W-1:0] step_up(input logic [W-1:0] v, input logic fill);
    return {v[W-2:0], fill};
  endfunction

  // move every bit one place toward the bottom, fill bit W-1
  function automatic logic [W-1:0] step_down(input logic [W-1:0] v, input logic fill);
    return {fill, v[W-1:1]};
  endfunction

  always_comb begin
    unique case (mode)
      MODE_UP:   nxt = step_up(cur, rin);
      MODE_DOWN: nxt = step_down(cur, lin);
      MODE_LOAD: nxt = pin;
      default:   nxt = cur;
    endcase
  end

  assign load_evt = (mode == MODE_LOAD);
  assign move_evt = (mode == MODE_UP) || (mode == MODE_DOWN);

endmodule

// File: rtl/ushr_store.sv
module ushr_store #(
  parameter int W          = 8,
  parameter bit CLEAR_SYNC = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (CLEAR_SYNC) begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/ushr_drive.sv
module ushr_drive
  import ushr_pkg::*;
#(
  parameter int W = 8
) (
  input  mode_e        mode,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         drive_on
);

  // both enables asserted and the port is not being read in
  assign drive_on = !oe_a_n && !oe_b_n && (mode != MODE_LOAD);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign pad_oe[i]  = drive_on;
      assign pad_out[i] = cur[i];
    end
  endgenerate

endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
  import ushr_pkg::*;
#(
  parameter int W          = 8,
  parameter bit CLEAR_SYNC = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode_sel,
  input  logic         ser_rin,
  input  logic         ser_lin,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         end_lo,
  output logic         end_hi
);

  localparam int TOP = W - 1;

  mode_e        mode;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         load_evt;
  logic         move_evt;
  logic         drive_on;

  assign mode = mode_e'(mode_sel);

  ushr_next #(.W(W)) u_next (
    .cur      (q_r),
    .mode     (mode),
    .rin      (ser_rin),
    .lin      (ser_lin),
    .pin      (pad_in),
    .nxt      (q_nxt),
    .load_evt (load_evt),
    .move_evt (move_evt)
  );

  ushr_store #(.W(W), .CLEAR_SYNC(CLEAR_SYNC)) u_store (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (q_nxt),
    .q     (q_r)
  );

  ushr_drive #(.W(W)) u_drive (
    .mode     (mode),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .cur      (q_r),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .drive_on (drive_on)
  );

  assign end_lo = q_r[0];
  assign end_hi = q_r[TOP];

endmodule

// File: rtl/ushr_chk.sv
module ushr_chk #(
  parameter int W          = 8,
  parameter bit CLEAR_SYNC = 1'b0
) (
  input logic         clk,
  input logic         clr_n,
  input logic [1:0]   mode_sel,
  input logic         ser_rin,
  input logic         ser_lin,
  input logic         oe_a_n,
  input logic         oe_b_n,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] q_r,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         end_lo,
  input logic         end_hi,
  input logic         load_evt,
  input logic         drive_on
);

  a_r1_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b00) |=> (q_r == $past(q_r)));

  a_r2_shift_up: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b01) |=> (q_r == {$past(q_r[W-2:0]), $past(ser_rin)}));

  a_r3_shift_down: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b10) |=> (q_r == {$past(ser_lin), $past(q_r[W-1:1])}));

  a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
    load_evt |=> (q_r == $past(pad_in)));

  a_r5_release_on_load: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b11) |-> (pad_oe == '0));

  a_r5_drive_when_enabled: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> (&pad_oe));

  a_r5_float_when_disabled: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n || oe_b_n) |-> (!drive_on && pad_oe == '0));

  a_r7_end_bits: assert property (@(posedge clk) disable iff (!clr_n)
    (end_lo == pad_out[0]) && (end_hi == pad_out[W-1]));

  generate
    if (!CLEAR_SYNC) begin : g_async_chk
      // R8: while clear is low the asynchronous variant shows zero
      a_r8_async_zero: assert property (@(posedge clk) disable iff (clr_n)
        !clr_n |-> (q_r == '0));
    end
  endgenerate

endmodule

bind univ_shreg ushr_chk #(.W(W), .CLEAR_SYNC(CLEAR_SYNC)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .mode_sel (mode_sel),
  .ser_rin  (ser_rin),
  .ser_lin  (ser_lin),
  .oe_a_n   (oe_a_n),
  .oe_b_n   (oe_b_n),
  .pad_in   (pad_in),
  .q_r      (q_r),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .end_lo   (end_lo),
  .end_hi   (end_hi),
  .load_evt (load_evt),
  .drive_on (drive_on)
);

// File: tb/univ_shreg_tb.sv
module univ_shreg_tb;

  localparam int W    = 8;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         clr_a_n = 1'b1;
  logic         clr_s_n = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic         ser_rin = 1'b0;
  logic         ser_lin = 1'b0;
  logic         oe_a_n = 1'b0;
  logic         oe_b_n = 1'b0;
  logic [W-1:0] pad_in = '0;

  logic [W-1:0] out_a, oe_a, out_s, oe_s;
  logic         lo_a, hi_a, lo_s, hi_s;

  univ_shreg #(.W(W), .CLEAR_SYNC(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_a_n), .mode_sel(mode_sel), .ser_rin(ser_rin),
    .ser_lin(ser_lin), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pad_in(pad_in),
    .pad_out(out_a), .pad_oe(oe_a), .end_lo(lo_a), .end_hi(hi_a)
  );

  univ_shreg #(.W(W), .CLEAR_SYNC(1'b1)) u_dut_sync (
    .clk(clk), .clr_n(clr_s_n), .mode_sel(mode_sel), .ser_rin(ser_rin),
    .ser_lin(ser_lin), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pad_in(pad_in),
    .pad_out(out_s), .pad_oe(oe_s), .end_lo(lo_s), .end_hi(hi_s)
  );

  int errors = 0;
  int checks = 0;
  int ma = 0;
  int ms = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int apply(input int v, input int md, input int r, input int l, input int p);
    case (md)
      1:       return (v * 2 + r) % SPAN;
      2:       return v / 2 + l * HALF;
      3:       return p;
      default: return v;
    endcase
  endfunction

  task automatic look(input string req);
    check({req, " async value"}, 32'(out_a), ma);
    check({req, " sync value"}, 32'(out_s), ms);
    check("R7 async ends", {30'd0, hi_a, lo_a}, {30'd0, 1'(ma / HALF), 1'(ma % 2)});
    check("R7 sync ends", {30'd0, hi_s, lo_s}, {30'd0, 1'(ms / HALF), 1'(ms % 2)});
  endtask

  // called at a falling edge; applies one mode for one rising edge
  task automatic cycle(input string req, input int md, input int r, input int l, input int p);
    mode_sel = 2'(md);
    ser_rin  = 1'(r);
    ser_lin  = 1'(l);
    pad_in   = W'(p);
    #1;
    begin
      int want = ((oe_a_n == 1'b0) && (oe_b_n == 1'b0) && md != 3) ? SPAN - 1 : 0;
      check("R5 async oe", 32'(oe_a), want);
      check("R5 sync oe", 32'(oe_s), want);
    end
    @(posedge clk);
    ma = apply(ma, md, r, l, p);
    ms = apply(ms, md, r, l, p);
    @(negedge clk);
    look(req);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // reset: async clear falls after time zero, sync clear held over edges
    #1 clr_a_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    ma = 0;
    ms = 0;
    look("R8 R9 reset");
    clr_a_n = 1'b1;
    clr_s_n = 1'b1;

    // R4 R6: every word through the load path
    for (int v = 0; v < SPAN; v++) cycle("R4 load", 3, 0, 0, v);

    // R1 R2 R3: every mode and serial pair from a spread of start values
    for (int k = 0; k < 16; k++) begin
      for (int md = 0; md < 3; md++) begin
        for (int rl = 0; rl < 4; rl++) begin
          cycle("R4 preload", 3, 0, 0, (k * 37 + 5) % SPAN);
          cycle(md == 0 ? "R1 hold" : (md == 1 ? "R2 shift up" : "R3 shift down"),
                md, rl % 2, rl / 2, SPAN - 1);
        end
      end
    end

    // R11 R5: enables high must not stop the register
    for (int e = 1; e < 4; e++) begin
      oe_a_n = 1'(e % 2);
      oe_b_n = 1'(e / 2);
      cycle("R11 load released", 3, 0, 0, 8'h3C);
      cycle("R11 shift up released", 1, 1, 0, 0);
      cycle("R11 shift down released", 2, 0, 1, 0);
      cycle("R11 hold released", 0, 0, 0, 0);
    end
    oe_a_n = 1'b0;
    oe_b_n = 1'b0;

    // R8 R9 R10: clear falling between edges, during a load of all ones
    cycle("R4 preload", 3, 0, 0, 8'hA5);
    mode_sel = 2'b11;
    pad_in   = '1;
    #1 clr_a_n = 1'b0;
    clr_s_n = 1'b0;
    #1;
    ma = 0;
    look("R8 immediate clear / R9 sync waits");
    @(posedge clk);
    ms = 0;
    @(negedge clk);
    look("R10 clear beats load");
    #1 clr_a_n = 1'b1;
    clr_s_n = 1'b1;
    @(negedge clk);

    // R9: a sync clear pulse between edges is ignored
    cycle("R4 preload", 3, 0, 0, 8'h5A);
    mode_sel = 2'b00;
    #1 clr_s_n = 1'b0;
    #1 clr_s_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    look("R9 short pulse ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule